// File: doc/BRIEF.md
# Two-Register Adder with Packed Flag Nibble

This block is a small byte-wide datapath holding two general registers, called accumulator and operand, plus a four-bit status register. A clocked command port carries an operation code, an immediate byte and a valid strobe. It accepts one command per clock and supports three operations: load the accumulator, load the operand, and add the operand into the accumulator.

An add computes four status bits and packs them into one nibble, so a consumer can compare all four at once. The bits are carry out, half carry (the carry from the low nibble into the high nibble), signed overflow, and odd parity of the result. A register update can be seen on the read ports one clock after the command is accepted.

Top module: `dual_reg_adder`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the operand and all four flag bits to zero.
- R2: With valid high and opcode 2'b01, the immediate byte is loaded into the accumulator. With opcode 2'b10, it is loaded into the operand. A load leaves the flag nibble unchanged, and the new value appears on the next cycle.
- R3: With valid high and opcode 2'b11, the 8-bit sum of accumulator and operand is written into the accumulator, and the operand keeps its value.
- R4: The flag nibble is {carry, half carry, overflow, parity}, with carry in bit 3 and parity in bit 0.
- R5: The carry bit is the carry out of bit 7 of the add. The half carry is the carry out of bit 3 into bit 4.
- R6: The overflow bit is set when both operands have the same sign bit and the result's sign bit differs from it.
- R7: The parity bit is 1 when the 8-bit result has an odd number of ones, and 0 when that count is even.
- R8: When valid is low, or the opcode is 2'b00, no register or flag changes.
- R9: Loading 0x60 and 0x46 and then adding gives an accumulator of 0xA6 and a flag nibble of 4'b0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code |
| cmd_imm | input | 8 | Immediate byte |
| acc | output | 8 | Accumulator value |
| opnd | output | 8 | Operand value |
| flags | output | 4 | Packed flag nibble {C, H, V, P} |

## Verification
The bench uses the default data width of 8, so every status bit can be reached with byte operands. Directed adds cover these cases:
- carry out without overflow;
- half carry alone;
- overflow from two positive operands;
- overflow from two negative operands;
- parity of both senses.

The worked 0x60 + 0x46 case is also run. After these, a long pseudo-random command stream is compared every clock against a behavioural model written with integers.

// File: rtl/adder_pkg.sv
package adder_pkg;
    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_LDACC = 2'b01,
        OP_LDOPD = 2'b10,
        OP_ADD   = 2'b11
    } op_e;

    typedef struct packed {
        logic cy;
        logic hc;
        logic ov;
        logic par;
    } flags_t;
endpackage

// File: rtl/add_flags.sv
module add_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    sum,
    output adder_pkg::flags_t fl
);
    localparam int HALF = W / 2;

    logic [HALF:0] low_sum;
    logic [W:0]    full_sum;
    logic [W-1:0]  low_part_sum;

    always_comb begin
        low_sum      = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]};
        full_sum     = {1'b0, a} + {1'b0, b};
        low_part_sum = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]};
        sum          = full_sum[W-1:0];
        fl.cy        = full_sum[W];
        fl.hc        = low_sum[HALF];
        fl.ov        = low_part_sum[W-1] ^ full_sum[W];
        fl.par       = ^full_sum[W-1:0];
    end
endmodule

// File: rtl/dual_reg_adder.sv
module dual_reg_adder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic [W-1:0] cmd_imm,
    output logic [W-1:0] acc,
    output logic [W-1:0] opnd,
    output logic [3:0]   flags
);
    import adder_pkg::*;

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] opnd;
        flags_t       fl;
    } state_t;

    state_t state_d, state_q;
    logic [W-1:0] sum;
    flags_t       add_fl;

    add_flags #(.W(W)) u_flags (
        .a  (state_q.acc),
        .b  (state_q.opnd),
        .sum(sum),
        .fl (add_fl)
    );

    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            case (op_e'(cmd_op))
                OP_LDACC: state_d.acc  = cmd_imm;
                OP_LDOPD: state_d.opnd = cmd_imm;
                OP_ADD: begin
                    state_d.acc = sum;
                    state_d.fl  = add_fl;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign acc   = state_q.acc;
    assign opnd  = state_q.opnd;
    assign flags = state_q.fl;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc == '0 && opnd == '0 && flags == 4'b0));

    assert_load_keeps_flags_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 2'b01 || cmd_op == 2'b10)) |=> $stable(flags));

    assert_add_keeps_opnd_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b11) |=> $stable(opnd));

    assert_parity_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b11) |=> (flags[0] == ^acc));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || cmd_op == 2'b00) |=> ($stable(acc) && $stable(opnd) && $stable(flags)));
endmodule

// File: tb/test_dual_reg_adder.sv
module test_dual_reg_adder;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [7:0] cmd_imm;
    logic [7:0] acc;
    logic [7:0] opnd;
    logic [3:0] flags;

    int checks = 0;
    int errors = 0;
    int m_acc, m_opnd, m_fl;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_reg_adder i_dual_reg_adder (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_imm(cmd_imm), .acc(acc), .opnd(opnd), .flags(flags)
    );

    // behavioural reference step
    task automatic model_step(input bit v, input int op, input int imm);
        int s, c, h, o, p, ones;
        if (!v) return;
        if (op == 1) m_acc = imm;
        else if (op == 2) m_opnd = imm;
        else if (op == 3) begin
            s = m_acc + m_opnd;
            c = (s > 255) ? 1 : 0;
            h = (((m_acc % 16) + (m_opnd % 16)) > 15) ? 1 : 0;
            o = ((m_acc >= 128) == (m_opnd >= 128) && ((s % 256) >= 128) != (m_acc >= 128)) ? 1 : 0;
            ones = 0;
            for (int i = 0; i < 8; i++) ones += ((s >> i) & 1);
            p = ones % 2;
            m_acc = s % 256;
            m_fl = c * 8 + h * 4 + o * 2 + p;
        end
    endtask

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, acc, m_acc);
        check(req, opnd, m_opnd);
        check(req, flags, m_fl);
    endtask

    task automatic cmd(input bit v, input int op, input int imm, input string req);
        @(negedge clk);
        cmd_valid = v;
        cmd_op = op[1:0];
        cmd_imm = imm[7:0];
        model_step(v, op, imm);
        @(negedge clk);
        cmd_valid = 1'b0;
        compare_all(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_imm = 8'h00;
        m_acc = 0; m_opnd = 0; m_fl = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare_all("R1");

        // R9 worked example, R2 loads
        cmd(1, 1, 8'h60, "R2");
        cmd(1, 2, 8'h46, "R2");
        cmd(1, 3, 0, "R3");
        check("R9", acc, 8'hA6);
        check("R9", flags, 4'b0010);

        // R2: load does not touch flags
        cmd(1, 1, 8'hFF, "R2");
        check("R2", flags, 4'b0010);
        // R5 carry: FF+01 -> 00, C=1 H=1 V=0 P=0
        cmd(1, 2, 8'h01, "R2");
        cmd(1, 3, 0, "R5");
        check("R5", flags, 4'b1100);
        check("R4", flags[3], 1);
        // R6 negative overflow: 80+80 -> 00, C=1 V=1
        cmd(1, 1, 8'h80, "R2");
        cmd(1, 2, 8'h80, "R2");
        cmd(1, 3, 0, "R6");
        check("R6", flags, 4'b1010);
        // R5 half carry: 08+08 -> 10, H=1 P=1
        cmd(1, 1, 8'h08, "R2");
        cmd(1, 2, 8'h08, "R2");
        cmd(1, 3, 0, "R5");
        check("R5", flags, 4'b0101);
        // R7 odd parity: 01+02 -> 03 even -> P=0; then 03+02=05 even; 05+02=07 odd
        cmd(1, 1, 8'h01, "R2");
        cmd(1, 2, 8'h02, "R2");
        cmd(1, 3, 0, "R7");
        check("R7", flags[0], 0);
        cmd(1, 3, 0, "R7");
        cmd(1, 3, 0, "R7");
        check("R7", flags[0], 1);
        // R8 ignored commands
        cmd(0, 1, 8'h55, "R8");
        cmd(0, 3, 0, "R8");
        cmd(1, 0, 8'hAA, "R8");
        check("R8", acc, 8'h07);

        // random stream
        for (int n = 0; n < 2000; n++) begin
            cmd($urandom_range(0, 4) != 0, $urandom_range(0, 3), $urandom_range(0, 255), "R3");
        end

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_acc = 0; m_opnd = 0; m_fl = 0;
        compare_all("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule